// File: doc/BRIEF.md
# Quadword Load Sequencer

This block carries out load instructions for a core whose registers are modelled at 32 bits, including a 128-bit "load quadword" instruction. An accepted instruction is decoded into a destination register, a base register and a 16-bit offset. The effective address is the base value plus the sign-extended offset. It is checked for alignment, and a correctly aligned access is then run as a request/response exchange on a word-wide memory port. The first returned word is written back to the destination register. Only that word is kept, because no storage exists for the upper 96 bits of a quadword.

The state machine has six states. `ST_IDLE` accepts an instruction. `ST_REQ` presents a read request. `ST_WAIT` waits for the read data. `ST_WB` raises the writeback pulse. `ST_FAULT` raises the address-error pulse. `ST_TRAP` raises the unsupported-opcode pulse.

The transitions are as follows:
- From `ST_IDLE`, an accepted instruction goes to `ST_TRAP` if its opcode is not handled. It goes to `ST_FAULT` if it is misaligned, and to `ST_REQ` otherwise.
- `ST_REQ` moves to `ST_WAIT` when the port accepts the request.
- `ST_WAIT` moves to `ST_WB` on the response to the last beat. On the response to any earlier beat it returns to `ST_REQ`.
- `ST_WB`, `ST_FAULT` and `ST_TRAP` each return to `ST_IDLE` after one cycle.

The parameter `QUAD_BEATS` selects how a quadword load reads memory. With 1, it reads a single word. With 4, it reads all four words and drops the last three.

Top module: `ldq_seq`

## Requirements
- R1: After reset the sequencer is idle: `issue_ready` is 1 and `mem_req_valid`, `wb_valid`, `fault_valid` and `trap_valid` are all 0.
- R2: The instruction fields are decoded as follows: opcode `[31:26]`, base register `[25:21]` (driven out on `base_idx` while idle), destination `[20:16]` and offset `[15:0]`. Opcode 6'h1E is load-quadword and 6'h23 is load-word. For example, 0x78A90000 is load-quadword with destination 9, base 5 and offset 0.
- R3: The effective address is the base register value plus the 16-bit offset sign-extended to 32 bits.
- R4: A load-quadword whose effective address has bits [3:0] not equal to 0 raises `fault_valid` for exactly one cycle, with `fault_addr` equal to that address. No memory request and no writeback occur, and the sequencer then returns to idle.
- R5: A load-word needs only bits [1:0] of the effective address to be 0. If they are not, it takes the same fault path as R4.
- R6: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is 1. The sequencer then waits for a `mem_rsp_valid` pulse before it issues the next request or writes back.
- R7: A completed load raises `wb_valid` for one cycle, with `wb_idx` set to the destination and `wb_data` set to the first word returned.
- R8: With `QUAD_BEATS`=4, a load-quadword issues reads at ea, ea+4, ea+8 and ea+12 in that order. Each read follows the response to the previous one, and the register result equals the single-beat result.
- R9: A load-word and a load-quadword at the same 16-byte-aligned address leave the same value in their destinations.
- R10: A load whose destination is register 0 still performs its reads but produces no `wb_valid` pulse.
- R11: An instruction with any other opcode raises `trap_valid` for one cycle, with no memory request and no writeback.
- R12: Each accepted instruction ends in at most one of writeback, fault or trap. `issue_ready` stays 0 until that outcome has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The sequencer is idle and accepts the instruction |
| issue_instr | input | 32 | Instruction word |
| base_idx | output | 5 | Index of the base register, for the register file read |
| base_val | input | XLEN | Value of the base register |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | The memory accepts the request |
| mem_req_addr | output | XLEN | Byte address of the word being read |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per request) |
| mem_rsp_data | input | XLEN | Read data |
| wb_valid | output | 1 | Register write pulse |
| wb_idx | output | 5 | Register written |
| wb_data | output | XLEN | Value written |
| fault_valid | output | 1 | Address-error pulse |
| fault_addr | output | XLEN | Faulting effective address |
| trap_valid | output | 1 | Unsupported-opcode pulse |

## Verification
The bench builds two instances side by side and drives them with the same instruction stream: `dut_i` with `QUAD_BEATS`=4 and a second instance with `QUAD_BEATS`=1. This makes it possible to compare the register results of the two read modes directly while checking the four-address burst order on one instance only. Each instance has its own memory model that stalls requests and delays responses in a pseudo-random pattern. These stalls test how the beat counter behaves across waits. Positive, negative and zero offsets, both alignment limits, a zero destination and unhandled opcodes are all issued.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    // Major opcodes recognised by the sequencer
    localparam logic [5:0] OPC_LDQUAD = 6'h1E;
    localparam logic [5:0] OPC_LDWORD = 6'h23;

    typedef enum logic [1:0] {
        LK_BAD  = 2'd0,
        LK_WORD = 2'd1,
        LK_QUAD = 2'd2
    } ld_kind_e;

    typedef struct packed {
        ld_kind_e    kind;
        logic [4:0]  base_idx;
        logic [4:0]  dst_idx;
        logic [15:0] imm;
    } ld_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WB    = 3'd3,
        ST_FAULT = 3'd4,
        ST_TRAP  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/ldq_decode.sv
module ldq_decode
    import ldq_pkg::*;
(
    input  logic [31:0] instr,
    output ld_dec_t     dec
);

    always_comb begin
        dec.base_idx = instr[25:21];
        dec.dst_idx  = instr[20:16];
        dec.imm      = instr[15:0];
        unique case (instr[31:26])
            OPC_LDQUAD: dec.kind = LK_QUAD;
            OPC_LDWORD: dec.kind = LK_WORD;
            default:    dec.kind = LK_BAD;   // strict trap, never a no-op
        endcase
    end

endmodule

// File: rtl/ldq_agu.sv
module ldq_agu
    import ldq_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int QUAD_ALIGN  = 4,
    parameter int WORD_ALIGN  = 2
) (
    input  logic [XLEN-1:0] base,
    input  logic [15:0]     imm,
    input  ld_kind_e        kind,
    output logic [XLEN-1:0] ea,
    output logic            misaligned
);

    localparam logic [XLEN-1:0] QUAD_MASK = XLEN'((64'd1 << QUAD_ALIGN) - 64'd1);
    localparam logic [XLEN-1:0] WORD_MASK = XLEN'((64'd1 << WORD_ALIGN) - 64'd1);

    logic [XLEN-1:0] imm_sx;

    always_comb begin
        imm_sx = {{(XLEN-16){imm[15]}}, imm};
        ea     = base + imm_sx;
        unique case (kind)
            LK_QUAD: misaligned = |(ea & QUAD_MASK);
            LK_WORD: misaligned = |(ea & WORD_MASK);
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldq_beat_ctr.sv
module ldq_beat_ctr #(
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [BW-1:0] last_idx,
    output logic [BW-1:0] beat,
    output logic          at_last
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clear) begin
            beat <= '0;
        end else if (advance) begin
            beat <= beat + 1'b1;
        end
    end

    assign at_last = (beat == last_idx);

endmodule

// File: rtl/ldq_seq.sv
module ldq_seq
    import ldq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int QUAD_BEATS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    output logic            issue_ready,
    input  logic [31:0]     issue_instr,
    output logic [4:0]      base_idx,
    input  logic [XLEN-1:0] base_val,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            wb_valid,
    output logic [4:0]      wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic            fault_valid,
    output logic [XLEN-1:0] fault_addr,
    output logic            trap_valid
);

    localparam int              BW         = (QUAD_BEATS > 1) ? $clog2(QUAD_BEATS) : 1;
    localparam logic [BW-1:0]   QUAD_LAST  = BW'(QUAD_BEATS - 1);
    localparam int              BEAT_SHIFT = $clog2(XLEN / 8);

    seq_state_e      state_q, state_d;
    ld_dec_t         dec_in;
    logic [XLEN-1:0] ea_in;
    logic            mis_in;
    logic            accept;
    logic            rsp_take;
    logic            capture;

    logic [4:0]      dst_q;
    logic [XLEN-1:0] ea_q;
    logic [BW-1:0]   last_q;
    logic [XLEN-1:0] data_q;
    logic [BW-1:0]   beat;
    logic            at_last;

    // ---------------- decode and address generation ----------------
    ldq_decode u_dec (
        .instr (issue_instr),
        .dec   (dec_in)
    );

    ldq_agu #(
        .XLEN       (XLEN),
        .QUAD_ALIGN (4),
        .WORD_ALIGN (2)
    ) u_agu (
        .base       (base_val),
        .imm        (dec_in.imm),
        .kind       (dec_in.kind),
        .ea         (ea_in),
        .misaligned (mis_in)
    );

    ldq_beat_ctr #(
        .BW (BW)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .advance  (rsp_take && !at_last),
        .last_idx (last_q),
        .beat     (beat),
        .at_last  (at_last)
    );

    assign accept   = issue_valid && (state_q == ST_IDLE);
    assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid;

    // Only the first beat carries the architecturally visible low word
    generate
        if (QUAD_BEATS > 1) begin : g_multi
            assign capture = rsp_take && (beat == '0);
        end else begin : g_single
            assign capture = rsp_take;
        end
    endgenerate

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_in.kind == LK_BAD) begin
                        state_d = ST_TRAP;
                    end else if (mis_in) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = at_last ? ST_WB : ST_REQ;
                end
            end
            ST_WB:    state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            ST_TRAP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- per-instruction data ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            ea_q   <= '0;
            last_q <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                dst_q  <= dec_in.dst_idx;
                ea_q   <= ea_in;
                last_q <= (dec_in.kind == LK_QUAD) ? QUAD_LAST : '0;
            end
            if (capture) begin
                data_q <= mem_rsp_data;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        issue_ready   = 1'b0;
        mem_req_valid = 1'b0;
        wb_valid      = 1'b0;
        fault_valid   = 1'b0;
        trap_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:  issue_ready   = 1'b1;
            ST_REQ:   mem_req_valid = 1'b1;
            ST_WAIT:  ;
            ST_WB:    wb_valid      = (dst_q != 5'd0);
            ST_FAULT: fault_valid   = 1'b1;
            ST_TRAP:  trap_valid    = 1'b1;
            default:  ;
        endcase
        base_idx     = dec_in.base_idx;
        mem_req_addr = ea_q + (XLEN'(beat) << BEAT_SHIFT);
        wb_idx       = dst_q;
        wb_data      = data_q;
        fault_addr   = ea_q;
    end

endmodule

// File: rtl/ldq_seq_chk.sv
module ldq_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            wb_valid,
    input logic [4:0]      wb_idx,
    input logic            fault_valid,
    input logic [XLEN-1:0] fault_addr,
    input logic            trap_valid
);

    // R4: fault is a single-cycle pulse, followed by idle
    p_fault_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid && issue_ready);

    // R4 / R5: a reported fault address is never quadword aligned
    p_fault_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_addr[3:0] != 4'd0));

    // R6: request is held with a stable address until accepted
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5: every request targets a word-aligned address
    p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'd0));

    // R10: register 0 is never written
    p_no_zero_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != 5'd0));

    // R11: trap lasts one cycle and returns to idle
    p_trap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid && issue_ready);

    // R12: at most one activity at a time
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, fault_valid, trap_valid, mem_req_valid}));

    // R12: no outcome while accepting instructions
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ready |-> !(wb_valid || fault_valid || trap_valid));

endmodule

bind ldq_seq ldq_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_ready   (issue_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_idx),
    .fault_valid   (fault_valid),
    .fault_addr    (fault_addr),
    .trap_valid    (trap_valid)
);

// File: tb/ldq_seq_tb_top.sv
package ldq_tb_pkg;
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ {a[31:16], 16'h0} ^ 32'h1357_9BDF;
    endfunction
endpackage

module ldq_mem_model #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    import ldq_tb_pkg::*;

    logic [15:0] lfsr;
    logic        pend;
    logic [31:0] pend_addr;
    logic [1:0]  dly;

    assign req_ready = req_valid && lfsr[0];

    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr      <= SEED;
            pend      <= 1'b0;
            pend_addr <= '0;
            dly       <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rsp_valid <= 1'b0;
            if (req_valid && req_ready) begin
                pend      <= 1'b1;
                pend_addr <= req_addr;
                dly       <= lfsr[2:1];
            end else if (pend) begin
                if (dly == 2'd0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= memf(pend_addr);
                    pend      <= 1'b0;
                end else begin
                    dly <= dly - 2'd1;
                end
            end
        end
    end
endmodule

module ldq_seq_tb_top;
    import ldq_tb_pkg::*;

    typedef struct packed {
        logic [1:0]  kind;   // 0 writeback, 1 fault, 2 trap
        logic [4:0]  idx;
        logic [31:0] val;
        logic [7:0]  rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic [31:0] breg [32];

    logic        a_ready, a_rv, a_rr, a_sv, a_wbv, a_fv, a_tv;
    logic [4:0]  a_bidx, a_wbi;
    logic [31:0] a_bval, a_ra, a_sd, a_wbd, a_fa;
    logic        b_ready, b_rv, b_rr, b_sv, b_wbv, b_fv, b_tv;
    logic [4:0]  b_bidx, b_wbi;
    logic [31:0] b_bval, b_ra, b_sd, b_wbd, b_fa;

    assign a_bval = breg[a_bidx];
    assign b_bval = breg[b_bidx];

    ldq_seq #(.XLEN(32), .QUAD_BEATS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(a_ready),
        .issue_instr(issue_instr), .base_idx(a_bidx), .base_val(a_bval),
        .mem_req_valid(a_rv), .mem_req_ready(a_rr), .mem_req_addr(a_ra),
        .mem_rsp_valid(a_sv), .mem_rsp_data(a_sd),
        .wb_valid(a_wbv), .wb_idx(a_wbi), .wb_data(a_wbd),
        .fault_valid(a_fv), .fault_addr(a_fa), .trap_valid(a_tv));

    ldq_seq #(.XLEN(32), .QUAD_BEATS(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(b_ready),
        .issue_instr(issue_instr), .base_idx(b_bidx), .base_val(b_bval),
        .mem_req_valid(b_rv), .mem_req_ready(b_rr), .mem_req_addr(b_ra),
        .mem_rsp_valid(b_sv), .mem_rsp_data(b_sd),
        .wb_valid(b_wbv), .wb_idx(b_wbi), .wb_data(b_wbd),
        .fault_valid(b_fv), .fault_addr(b_fa), .trap_valid(b_tv));

    ldq_mem_model #(.SEED(16'hACE1)) mem_a (
        .clk(clk), .rst_n(rst_n), .req_valid(a_rv), .req_ready(a_rr), .req_addr(a_ra),
        .rsp_valid(a_sv), .rsp_data(a_sd));
    ldq_mem_model #(.SEED(16'h5A3C)) mem_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_rv), .req_ready(b_rr), .req_addr(b_ra),
        .rsp_valid(b_sv), .rsp_data(b_sd));

    int checks = 0;
    int errors = 0;
    exp_t        qa_res[$], qb_res[$];
    logic [31:0] qa_addr[$], qb_addr[$];

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Monitor: compares requests and outcomes of one instance with its queues
    task automatic mon(input int which, input logic rv, input logic rr, input logic [31:0] ra,
                       input logic wbv, input logic [4:0] wbi, input logic [31:0] wbd,
                       input logic fv, input logic [31:0] fa, input logic tv);
        exp_t        e;
        logic [31:0] ea;
        int          n;
        if (rv && rr) begin
            // R8 (four-beat order) on dut_i, R6 on the single-beat instance
            n = (which == 0) ? qa_addr.size() : qb_addr.size();
            if (n == 0) begin
                check(1'b0, (which == 0) ? 8 : 6, "unexpected request", ra, 32'h0);
            end else begin
                ea = (which == 0) ? qa_addr.pop_front() : qb_addr.pop_front();
                check(ra == ea, (which == 0) ? 8 : 6, "request address", ra, ea);
            end
        end
        if (wbv || fv || tv) begin
            n = (which == 0) ? qa_res.size() : qb_res.size();
            if (n == 0) begin
                check(1'b0, 12, "unexpected outcome", {27'h0, wbi}, 32'h0);
            end else begin
                e = (which == 0) ? qa_res.pop_front() : qb_res.pop_front();
                if (wbv) begin
                    check(e.kind == 2'd0, int'(e.rq), "outcome kind (wb)", 32'd0, {30'h0, e.kind});
                    check(wbi == e.idx, int'(e.rq), "wb destination", {27'h0, wbi}, {27'h0, e.idx});
                    check(wbd == e.val, int'(e.rq), "wb data", wbd, e.val);
                end else if (fv) begin
                    check(e.kind == 2'd1, int'(e.rq), "outcome kind (fault)", 32'd1, {30'h0, e.kind});
                    check(fa == e.val, int'(e.rq), "fault address", fa, e.val);
                end else begin
                    check(e.kind == 2'd2, int'(e.rq), "outcome kind (trap)", 32'd2, {30'h0, e.kind});
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon(0, a_rv, a_rr, a_ra, a_wbv, a_wbi, a_wbd, a_fv, a_fa, a_tv);
            mon(1, b_rv, b_rr, b_ra, b_wbv, b_wbi, b_wbd, b_fv, b_fa, b_tv);
        end
    end

    // Driver: computes expected items from the requirements, then issues
    task automatic issue(input logic [31:0] instr, input int rq);
        logic [5:0]  opc;
        logic [4:0]  rt;
        logic [31:0] ea;
        exp_t        e;
        opc = instr[31:26];
        rt  = instr[20:16];
        ea  = breg[instr[25:21]] + {{16{instr[15]}}, instr[15:0]};      // R3
        e.rq = 8'(rq);
        e.idx = rt;
        if (opc == 6'h1E || opc == 6'h23) begin
            if ((opc == 6'h1E && ea[3:0] != 4'd0) || (opc == 6'h23 && ea[1:0] != 2'd0)) begin
                e.kind = 2'd1; e.val = ea;                                  // R4, R5
                qa_res.push_back(e); qb_res.push_back(e);
            end else begin
                if (opc == 6'h1E) begin
                    for (int k = 0; k < 4; k++) qa_addr.push_back(ea + 32'(4 * k)); // R8
                end else begin
                    qa_addr.push_back(ea);
                end
                qb_addr.push_back(ea);
                if (rt != 5'd0) begin                                       // R10
                    e.kind = 2'd0; e.val = memf(ea);                        // R7
                    qa_res.push_back(e); qb_res.push_back(e);
                end
            end
        end else begin
            e.kind = 2'd2; e.val = 32'h0;                                   // R11
            qa_res.push_back(e); qb_res.push_back(e);
        end
        @(negedge clk);
        issue_valid = 1'b1;
        issue_instr = instr;
        @(negedge clk);
        issue_valid = 1'b0;
        check(!a_ready && !b_ready, 12, "busy after accept", {31'h0, a_ready | b_ready}, 32'h0);
        while (!(a_ready && b_ready)) @(negedge clk);
        check(qa_res.size() == 0 && qa_addr.size() == 0, rq, "dut_i outstanding items",
              32'(qa_res.size() + qa_addr.size()), 32'h0);
        check(qb_res.size() == 0 && qb_addr.size() == 0, rq, "single-beat outstanding items",
              32'(qb_res.size() + qb_addr.size()), 32'h0);
    endtask

    function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] off);
        return {opc, rs, rt, off};
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) breg[i] = 32'h0000_0100 * i;
        breg[5] = 32'h0000_2000;
        breg[6] = 32'h0000_1008;
        breg[7] = 32'h0001_0010;
        breg[8] = 32'h0000_3004;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(a_ready && b_ready, 1, "issue_ready after reset", {31'h0, a_ready & b_ready}, 32'h1);
        check(!a_rv && !b_rv, 1, "no request after reset", {31'h0, a_rv | b_rv}, 32'h0);
        check(!(a_wbv || a_fv || a_tv || b_wbv || b_fv || b_tv), 1, "no pulse after reset",
              {31'h0, a_wbv | a_fv | a_tv | b_wbv | b_fv | b_tv}, 32'h0);

        // R2: the reference encoding decodes to quad load t1 <- 0(a1)
        check(enc(6'h1E, 5'd5, 5'd9, 16'h0) == 32'h78A9_0000, 2, "encoding", enc(6'h1E, 5'd5, 5'd9, 16'h0), 32'h78A9_0000);
        issue(32'h78A9_0000, 2);
        // R9: word load at the same address into another register
        issue(enc(6'h23, 5'd5, 5'd10, 16'h0000), 9);
        // R3: positive and negative offsets
        issue(enc(6'h1E, 5'd6, 5'd11, 16'h0008), 3);
        issue(enc(6'h1E, 5'd7, 5'd12, 16'hFFF0), 3);
        issue(enc(6'h1E, 5'd8, 5'd13, 16'hFFFC), 3);
        // R4: quad misalignment
        issue(enc(6'h1E, 5'd5, 5'd14, 16'h0004), 4);
        issue(enc(6'h1E, 5'd8, 5'd14, 16'h0000), 4);
        issue(enc(6'h1E, 5'd5, 5'd14, 16'h0001), 4);
        // R5: word alignment limits
        issue(enc(6'h23, 5'd5, 5'd15, 16'h0004), 5);
        issue(enc(6'h23, 5'd5, 5'd15, 16'h0002), 5);
        // R10: destination zero
        issue(enc(6'h1E, 5'd5, 5'd0, 16'h0020), 10);
        issue(enc(6'h23, 5'd5, 5'd0, 16'h0024), 10);
        // R11: unhandled opcodes
        issue(enc(6'h1F, 5'd5, 5'd3, 16'h0000), 11);
        issue(enc(6'h1C, 5'd9, 5'd9, 16'h5389), 11);
        // R6 / R8: a run of loads under varied stalls
        for (int k = 0; k < 24; k++) begin
            issue(enc((k % 3 == 0) ? 6'h23 : 6'h1E, 5'(k + 1), 5'(k % 31 + 1),
                      16'(k * 16 - 128)), 8);
        end
        // R7 / R9: same address through both instruction kinds again
        issue(enc(6'h1E, 5'd7, 5'd20, 16'h0030), 7);
        issue(enc(6'h23, 5'd7, 5'd21, 16'h0030), 9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule